// File: doc/BRIEF.md
# Boot-Region Erase Guard

This block sits beside the command sequencer of a byte-wide flash array of 256K locations. For every accepted request it works out which of the five array regions the operation may touch: the boot region, two small parameter regions and two large main regions. It returns that answer as a mask, together with a flag that says the request must finish without touching the array. The sequencer supplies the request kind and the latched address. A configuration input selects whether the boot region sits at the bottom or at the top of the address space.

The block also keeps a sticky lock bit that protects the boot region. A lock request sets the bit, and only the block reset clears it. While the lock is in force, chip erase leaves the boot region alone and byte programs aimed at it are refused. A high-voltage override input suspends the lock for as long as it is held, and the stored bit does not change. An identification read at offset 2 reports the stored lock bit, so software can find out whether the boot region is protected.

Top module: `boot_erase_guard`

## Requirements
- R1: After reset, res_valid, res_mask, res_noop, res_id and locked are all zero.
- R2: A request sampled with req_valid high at a clock edge produces its result on the outputs after that same edge. res_valid is high for exactly one cycle per request. With no request, res_mask, res_noop and res_id keep their last values.
- R3: With boot_top low (bottom map), a sector erase (req_kind 0) gives a one-hot res_mask. The mask bits are: bit 0 boot, bit 1 parameter 1, bit 2 parameter 2, bit 3 main 1, bit 4 main 2. The regions are: parameter 1 at 04000–05FFF (bit 1), parameter 2 at 06000–07FFF (bit 2), main 2 at 20000–3FFFF (bit 4).
- R4: With boot_top high (top map), the same bit assignment holds. The regions are: parameter 1 at 3A000–3BFFF, parameter 2 at 38000–39FFF, main 2 at 00000–1FFFF.
- R5: A sector erase whose address falls in the boot region (00000–03FFF on the bottom map, 3C000–3FFFF on the top map) gives res_noop high and res_mask zero.
- R6: A sector erase whose address falls in main 1 (08000–1FFFF on the bottom map, 20000–37FFF on the top map) gives res_mask 5'b01110: main 1 together with both parameter regions.
- R7: A chip erase (req_kind 1) gives res_mask 5'b11111 while the lock is not in force, and 5'b11110 while it is.
- R8: A byte program (req_kind 2) gives the one-hot mask of the region holding its address. If the address is in the boot region while the lock is in force, the program gives res_noop high and res_mask zero.
- R9: A lock request (req_kind 3) sets locked from the next cycle on. Only rst_n clears it.
- R10: While hv_override is high, the lock is not in force for chip erase or program, and locked keeps its value. Once hv_override is low again, the lock is back in force.
- R11: An identification read (req_kind 4) at offset 2 gives res_id = {7'b0, locked}. At any other offset it gives res_id = 8'h00. In both cases res_mask is zero and res_noop is low.
- R12: Address bits above bit 17 are ignored for every request kind.
- R13: Request kinds 5, 6 and 7 give res_noop high and res_mask zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also clears the lock |
| boot_top | input | 1 | 1 = boot region at the top of the map, 0 = at the bottom |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 sector erase, 1 chip erase, 2 program, 3 lock, 4 identification read |
| req_addr | input | 20 | Latched address; only the low 18 bits are used |
| hv_override | input | 1 | High-voltage override; suspends the lock while high |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_mask | output | 5 | Regions the request may touch (bit 0 boot … bit 4 main 2) |
| res_noop | output | 1 | Request must complete without touching the array |
| res_id | output | 8 | Identification read data |
| locked | output | 1 | Stored lock bit |

## Verification
Every result lands one register after the edge that samples the request. The bench drives a request on a falling edge and samples the outputs on the next falling edge. At that point the result edge has just passed, and the following request has not yet been sampled. A lock request changes the lock in force from the very next request, so the bench checks the request right after the lock. It also checks the case one cycle later, after hv_override is raised or dropped at a falling edge. The one-cycle width of res_valid and the holding of the result fields are checked on an idle cycle that follows a request.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
    localparam int NREG = 5;

    localparam int RG_BOOT  = 0;
    localparam int RG_PAR1  = 1;
    localparam int RG_PAR2  = 2;
    localparam int RG_MAIN1 = 3;
    localparam int RG_MAIN2 = 4;

    localparam logic [2:0] OP_SECT = 3'd0;
    localparam logic [2:0] OP_CHIP = 3'd1;
    localparam logic [2:0] OP_PROG = 3'd2;
    localparam logic [2:0] OP_LOCK = 3'd3;
    localparam logic [2:0] OP_IDRD = 3'd4;

    typedef struct packed {
        logic            valid;
        logic [NREG-1:0] mask;
        logic            noop;
        logic [7:0]      id;
    } res_t;
endpackage

// File: rtl/bfl_region_decode.sv
module bfl_region_decode
    import bfl_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic [AW-1:0]   addr,
    input  logic            top,
    output logic [NREG-1:0] hit
);
    // The top map is the bottom map mirrored through the address space.
    localparam int B_HALF  = AW - 1;
    localparam int B_QHI   = AW - 2;
    localparam int B_QLO   = AW - 3;
    localparam int B_BOOT  = AW - 4;
    localparam int B_PARAM = AW - 5;

    logic [AW-1:0] norm;

    always_comb begin
        norm = top ? ~addr : addr;
        hit  = '0;
        if (norm[B_HALF])
            hit[RG_MAIN2] = 1'b1;
        else if (norm[B_QHI] || norm[B_QLO])
            hit[RG_MAIN1] = 1'b1;
        else if (!norm[B_BOOT])
            hit[RG_BOOT] = 1'b1;
        else if (!norm[B_PARAM])
            hit[RG_PAR1] = 1'b1;
        else
            hit[RG_PAR2] = 1'b1;
    end
endmodule

// File: rtl/bfl_lock_keeper.sv
module bfl_lock_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic hv_override,
    output logic lock_q,
    output logic lock_eff
);
    logic lock_d;

    always_comb begin
        lock_d   = lock_q | set_req;
        lock_eff = lock_q & ~hv_override;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);                                   // R9
    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> lock_q);                                  // R9
    AST_OVERRIDE_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        hv_override |-> !lock_eff);                           // R10
endmodule

// File: rtl/bfl_erase_mapper.sv
module bfl_erase_mapper
    import bfl_pkg::*;
(
    input  logic [2:0]      kind,
    input  logic [NREG-1:0] hit,
    input  logic            lock_eff,
    output logic [NREG-1:0] mask,
    output logic            noop
);
    always_comb begin
        mask = '0;
        noop = 1'b0;
        case (kind)
            OP_SECT: begin
                if (hit[RG_BOOT]) begin
                    noop = 1'b1;
                end else if (hit[RG_MAIN1]) begin
                    mask           = hit;
                    mask[RG_PAR1]  = 1'b1;
                    mask[RG_PAR2]  = 1'b1;
                end else begin
                    mask = hit;
                end
            end
            OP_CHIP: begin
                mask = '1;
                if (lock_eff) mask[RG_BOOT] = 1'b0;
            end
            OP_PROG: begin
                if (hit[RG_BOOT] && lock_eff) noop = 1'b1;
                else                          mask = hit;
            end
            OP_LOCK, OP_IDRD: begin
                mask = '0;
            end
            default: noop = 1'b1;
        endcase
    end
endmodule

// File: rtl/boot_erase_guard.sv
module boot_erase_guard
    import bfl_pkg::*;
#(
    parameter int ADDR_IN_W = 20,
    parameter int AW        = 18,
    parameter int ID_LOCK_OFS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_top,
    input  logic                 req_valid,
    input  logic [2:0]           req_kind,
    input  logic [ADDR_IN_W-1:0] req_addr,
    input  logic                 hv_override,
    output logic                 res_valid,
    output logic [NREG-1:0]      res_mask,
    output logic                 res_noop,
    output logic [7:0]           res_id,
    output logic                 locked
);
    logic [AW-1:0]   addr_m;
    logic [NREG-1:0] region_hit;
    logic [NREG-1:0] map_mask;
    logic            map_noop;
    logic            lock_q;
    logic            lock_eff;
    res_t            st_d, st_q;

    assign addr_m = req_addr[AW-1:0];

    bfl_region_decode #(.AW(AW)) u_decode (
        .addr (addr_m),
        .top  (boot_top),
        .hit  (region_hit)
    );

    bfl_lock_keeper u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (req_valid && (req_kind == OP_LOCK)),
        .hv_override (hv_override),
        .lock_q      (lock_q),
        .lock_eff    (lock_eff)
    );

    bfl_erase_mapper u_map (
        .kind     (req_kind),
        .hit      (region_hit),
        .lock_eff (lock_eff),
        .mask     (map_mask),
        .noop     (map_noop)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.mask = map_mask;
            st_d.noop = map_noop;
            st_d.id   = '0;
            if (req_kind == OP_IDRD && addr_m == AW'(ID_LOCK_OFS))
                st_d.id = {7'b0, lock_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_mask  = st_q.mask;
    assign res_noop  = st_q.noop;
    assign res_id    = st_q.id;
    assign locked    = lock_q;

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                          // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);                                        // R2
    AST_BOOT_SECTOR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == OP_SECT && region_hit[RG_BOOT])
        |=> (res_noop && res_mask == '0));                                 // R5
    AST_MAIN1_PULLS_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == OP_SECT && region_hit[RG_MAIN1])
        |=> (res_mask == 5'b01110));                                       // R6
    AST_CHIP_SPARES_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == OP_CHIP && lock_eff)
        |=> !res_mask[RG_BOOT]);                                           // R7
    AST_NOOP_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        res_noop |-> (res_mask == '0));                                    // R13
endmodule

// File: tb/boot_erase_guard_tb.sv
module boot_erase_guard_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_top = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_addr = '0;
    logic        hv_override = 1'b0;
    logic        res_valid;
    logic [4:0]  res_mask;
    logic        res_noop;
    logic [7:0]  res_id;
    logic        locked;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_erase_guard u_dut (
        .clk(clk), .rst_n(rst_n), .boot_top(boot_top),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .hv_override(hv_override), .res_valid(res_valid), .res_mask(res_mask),
        .res_noop(res_noop), .res_id(res_id), .locked(locked)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        hv_override = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive at a falling edge; the result is sampled at the next falling edge.
    task automatic issue(logic [2:0] kind, logic [19:0] addr);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(string req, logic [2:0] kind, logic [19:0] addr,
                              logic [4:0] mask, logic noop);
        issue(kind, addr);
        check(req, "valid", 8'(res_valid), 8'h01);
        check(req, "mask", 8'(res_mask), 8'(mask));
        check(req, "noop", 8'(res_noop), 8'(noop));
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "valid", 8'(res_valid), 8'h00);
        check("R1", "mask", 8'(res_mask), 8'h00);
        check("R1", "noop", 8'(res_noop), 8'h00);
        check("R1", "id", res_id, 8'h00);
        check("R1", "locked", 8'(locked), 8'h00);
    endtask

    task automatic t_bottom_map();
        do_reset();
        boot_top = 1'b0;
        expect_res("R3", 3'd0, 20'h04100, 5'b00010, 1'b0);
        expect_res("R3", 3'd0, 20'h07FFF, 5'b00100, 1'b0);
        expect_res("R3", 3'd0, 20'h20000, 5'b10000, 1'b0);
        expect_res("R3", 3'd0, 20'h3FFFF, 5'b10000, 1'b0);
        expect_res("R5", 3'd0, 20'h00000, 5'b00000, 1'b1);
        expect_res("R5", 3'd0, 20'h03FFF, 5'b00000, 1'b1);
        expect_res("R6", 3'd0, 20'h08000, 5'b01110, 1'b0);
        expect_res("R6", 3'd0, 20'h1FFFF, 5'b01110, 1'b0);
    endtask

    task automatic t_top_map();
        do_reset();
        boot_top = 1'b1;
        expect_res("R4", 3'd0, 20'h3A000, 5'b00010, 1'b0);
        expect_res("R4", 3'd0, 20'h39FFF, 5'b00100, 1'b0);
        expect_res("R4", 3'd0, 20'h00000, 5'b10000, 1'b0);
        expect_res("R4", 3'd0, 20'h1FFFF, 5'b10000, 1'b0);
        expect_res("R5", 3'd0, 20'h3C000, 5'b00000, 1'b1);
        expect_res("R6", 3'd0, 20'h20000, 5'b01110, 1'b0);
        expect_res("R6", 3'd0, 20'h37FFF, 5'b01110, 1'b0);
        boot_top = 1'b0;
    endtask

    task automatic t_pulse_hold();
        do_reset();
        expect_res("R2", 3'd0, 20'h05000, 5'b00010, 1'b0);
        @(negedge clk);
        check("R2", "valid idle", 8'(res_valid), 8'h00);
        check("R2", "mask held", 8'(res_mask), 8'h02);
    endtask

    task automatic t_lock_flow();
        do_reset();
        expect_res("R7", 3'd1, 20'h00000, 5'b11111, 1'b0);
        expect_res("R8", 3'd2, 20'h00010, 5'b00001, 1'b0);
        expect_res("R8", 3'd2, 20'h30000, 5'b10000, 1'b0);
        expect_res("R11", 3'd4, 20'h00002, 5'b00000, 1'b0);
        check("R11", "id unlocked", res_id, 8'h00);
        issue(3'd3, 20'h05555);
        check("R9", "locked", 8'(locked), 8'h01);
        expect_res("R11", 3'd4, 20'h00002, 5'b00000, 1'b0);
        check("R11", "id locked", res_id, 8'h01);
        expect_res("R11", 3'd4, 20'h00001, 5'b00000, 1'b0);
        check("R11", "id other ofs", res_id, 8'h00);
        expect_res("R7", 3'd1, 20'h00000, 5'b11110, 1'b0);
        expect_res("R8", 3'd2, 20'h00010, 5'b00000, 1'b1);
        expect_res("R8", 3'd2, 20'h05000, 5'b00010, 1'b0);
        @(negedge clk);
        hv_override = 1'b1;
        expect_res("R10", 3'd1, 20'h00000, 5'b11111, 1'b0);
        expect_res("R10", 3'd2, 20'h00010, 5'b00001, 1'b0);
        check("R10", "locked kept", 8'(locked), 8'h01);
        @(negedge clk);
        hv_override = 1'b0;
        expect_res("R10", 3'd1, 20'h00000, 5'b11110, 1'b0);
        expect_res("R12", 3'd4, 20'hC0002, 5'b00000, 1'b0);
        check("R12", "id high bits", res_id, 8'h01);
        do_reset();
        check("R9", "cleared by reset", 8'(locked), 8'h00);
    endtask

    task automatic t_upper_bits();
        do_reset();
        boot_top = 1'b0;
        expect_res("R12", 3'd0, 20'hC4000, 5'b00010, 1'b0);
        expect_res("R12", 3'd0, 20'hA0000, 5'b10000, 1'b0);
        boot_top = 1'b1;
        expect_res("R12", 3'd0, 20'hFFFFF, 5'b00000, 1'b1);
        boot_top = 1'b0;
    endtask

    task automatic t_unused_kinds();
        do_reset();
        for (int k = 5; k < 8; k++)
            expect_res("R13", 3'(k), 20'h20000, 5'b00000, 1'b1);
    endtask

    initial begin
        t_reset();
        t_bottom_map();
        t_top_map();
        t_pulse_hold();
        t_lock_flow();
        t_upper_bits();
        t_unused_kinds();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule